// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a one-cycle baud-rate enable from a fast system clock. Instead of an integer divider, it uses a phase accumulator. The phase is a 16-bit fraction of one bit period. On every clock edge where the serial transmitter reports that it is sending, a constant step is added to the phase. When the sum carries out of the fraction, a tick is produced for one cycle. Because the step is a rounded value, the average tick rate follows the target baud rate closely even when the clock is not an integer multiple of it.

The system clock frequency and the target baud rate are elaboration-time parameters, and the step is derived from them when the design is elaborated. The transmitter's busy flag gates the accumulator. While the line is idle, the phase is held at zero, so each frame begins from the same phase. The shift logic of the transmitter sits outside this block and consumes the tick as a shift enable.

Top module: `baud_tick_gen`

## Requirements
- R1: The step is STEP = ((BAUD_HZ << (ACC_W-4)) + (CLK_HZ >> 5)) / (CLK_HZ >> 4), using integer division. This gives 151 for a 50 MHz clock at 115200 baud, 16384 for 1 MHz at 250000 baud, and 39322 for 1 MHz at 600000 baud.
- R2: On each rising edge with `tx_busy` high, the ACC_W-bit phase becomes (phase + STEP) mod 2^ACC_W. `baud_tick` is high in the following cycle exactly when that addition carried out. Starting from zero phase, n busy edges therefore produce floor(n·STEP / 2^ACC_W) ticks.
- R3: Each carry gives a tick that lasts exactly one cycle. When STEP < 2^(ACC_W-1), no two ticks fall on adjacent cycles. With a larger STEP, adjacent ticks do occur.
- R4: A rising edge with `tx_busy` low clears the phase to zero, and `baud_tick` stays low while `tx_busy` stays low. A phase built up before an idle gap is therefore discarded.
- R5: `rst_n` is an active-low synchronous reset. A rising edge with `rst_n` low clears the phase, and `baud_tick` is low in the following cycle, even if `tx_busy` is high.
- R6: After a clear, the first tick appears after exactly ceil(2^ACC_W / STEP) busy edges: 435 edges for STEP 151, and 4 edges for STEP 16384, where the sum hits 2^ACC_W exactly.
- R7: The average tick rate is CLK_HZ·STEP / 2^ACC_W. Over a long run this is within 0.5 % of BAUD_HZ for each of the five clock and baud pairs named above and below (12 MHz/921600, 25 MHz/460800).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_busy | input | 1 | Transmitter busy; advances the phase while high, clears it while low |
| baud_tick | output | 1 | One-cycle baud enable (carry out of the phase) |

## Verification
Every result comes from a single register stage. A tick, a cleared phase after an idle edge, and the effect of reset are all visible in the cycle after the rising edge that caused them. The first tick after a clear is due exactly ceil(2^16/STEP) busy edges later. The bench changes inputs on falling edges and samples `baud_tick` on the falling edge after each rising edge, so each count of edges maps to exactly one sample. Rate checks count ticks over a 100000-cycle window with the phase starting at zero. The expected count is therefore the exact floor value, not an approximation.

// File: rtl/baud_tick_pkg.sv
// Package: shared helper for the fractional baud tick generator.
// Assumes CLK_HZ >= 32 and BAUD_HZ < CLK_HZ, so the step fits in ACC_W bits.
package baud_tick_pkg;

    // Rounded phase step for one clock of CLK_HZ at a rate of BAUD_HZ.
    function automatic longint step_for(input longint clk_hz,
                                        input longint baud_hz,
                                        input int unsigned acc_w);
        return ((baud_hz << (acc_w - 4)) + (clk_hz >> 5)) / (clk_hz >> 4);
    endfunction

endpackage

// File: rtl/baud_phase_acc.sv
// Module: phase accumulator with carry out.
// Adds STEP to the low ACC_W bits on each enabled edge. The top bit holds the
// carry of the last addition, and the previous carry is dropped each time.
// Assumes STEP < 2**ACC_W. Reset is synchronous and active low.
module baud_phase_acc #(
    parameter int unsigned     ACC_W = 16,
    parameter logic [ACC_W:0]  STEP  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ACC_W:0]   acc_q
);

    // Advance the phase while enabled; otherwise hold it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (adv) begin
            acc_q <= {1'b0, acc_q[ACC_W-1:0]} + STEP;
        end else begin
            acc_q <= '0;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
// Module: fractional baud tick generator (top).
// Derives the phase step from CLK_HZ and BAUD_HZ at elaboration. Runs the
// accumulator while the transmitter is busy and exports the carry as a
// one-cycle tick. Assumes BAUD_HZ is well below CLK_HZ.
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter longint      CLK_HZ  = 50_000_000,
    parameter longint      BAUD_HZ = 115_200,
    parameter int unsigned ACC_W   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_busy,
    output logic baud_tick
);

    localparam longint         STEP_L = step_for(CLK_HZ, BAUD_HZ, ACC_W);
    localparam logic [ACC_W:0] STEP   = (ACC_W+1)'(STEP_L);

    logic [ACC_W:0] acc_q;

    baud_phase_acc #(
        .ACC_W (ACC_W),
        .STEP  (STEP)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tx_busy),
        .acc_q (acc_q)
    );

    // The tick is the carry bit of the most recent addition.
    assign baud_tick = acc_q[ACC_W];

endmodule

// File: rtl/baud_tick_gen_chk.sv
// Checker: temporal properties of the fractional baud tick generator.
// Bound into every baud_tick_gen instance. It observes the ports and the
// phase held by the accumulator.
module baud_tick_gen_chk #(
    parameter int unsigned    ACC_W = 16,
    parameter logic [ACC_W:0] STEP  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_busy,
    input logic             baud_tick,
    input logic [ACC_W-1:0] phase
);

    // R5: a reset edge leaves no tick and a zero phase.
    assert_reset_clears_R5: assert property (@(posedge clk)
        !rst_n |=> (!baud_tick && phase == '0));

    // R4: an idle edge clears the phase and suppresses the tick.
    assert_idle_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |=> (!baud_tick && phase == '0));

    // R2: a busy edge adds the step; the carry becomes the tick.
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> ({baud_tick, phase} == ({1'b0, $past(phase)} + STEP)));

    // R2: a tick only follows a busy edge.
    assert_tick_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(tx_busy));

    // R3: with a step below half the range, ticks never touch.
    if (STEP < (ACC_W+1)'(1 << (ACC_W-1))) begin : g_sparse
        assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
            baud_tick |=> !baud_tick);
    end

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
    .ACC_W (ACC_W),
    .STEP  (STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_busy   (tx_busy),
    .baud_tick (baud_tick),
    .phase     (acc_q[ACC_W-1:0])
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;

    localparam int W      = 16;
    localparam int NCFG   = 5;
    localparam int MEAS_N = 100000;
    localparam longint CFG_CLK  [NCFG] = '{50_000_000, 12_000_000, 25_000_000, 1_000_000, 1_000_000};
    localparam longint CFG_BAUD [NCFG] = '{115_200, 921_600, 460_800, 250_000, 600_000};

    logic            clk     = 1'b0;
    logic            rst_n   = 1'b0;
    logic            tx_busy = 1'b0;
    logic [NCFG-1:0] tk;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
        baud_tick_gen #(
            .CLK_HZ  (CFG_CLK[gi]),
            .BAUD_HZ (CFG_BAUD[gi]),
            .ACC_W   (W)
        ) dut (
            .clk       (clk),
            .rst_n     (rst_n),
            .tx_busy   (tx_busy),
            .baud_tick (tk[gi])
        );
    end

    // Step as stated in R1.
    function automatic longint exp_step(input longint c, input longint b);
        return ((b << (W - 4)) + (c >> 5)) / (c >> 4);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance one rising edge and sample at the following falling edge.
    task automatic step_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Count busy edges until instance idx ticks (0 if none within limit).
    task automatic cycles_to_tick(input int idx, input int limit, output int n);
        n = 0;
        for (int k = 1; k <= limit; k++) begin
            step_cycle();
            if (tk[idx]) begin
                n = k;
                return;
            end
        end
    endtask

    task automatic idle(input int n);
        tx_busy = 1'b0;
        repeat (n) step_cycle();
    endtask

    initial begin
        longint cnt  [NCFG];
        longint adj  [NCFG];
        bit     prev [NCFG];
        int     n;
        int     bad;
        longint s0;
        longint first0;

        s0     = exp_step(CFG_CLK[0], CFG_BAUD[0]);
        first0 = ((longint'(1) << W) + s0 - 1) / s0;

        // R5: reset state.
        repeat (3) @(negedge clk);
        check(tk == '0, "R5", "ticks during reset", longint'(tk), 0);
        rst_n = 1'b1;

        // R4: idle line produces no ticks.
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            step_cycle();
            if (tk != '0) bad++;
        end
        check(bad == 0, "R4", "ticks while idle", bad, 0);

        // Long measurement over all parameter sets at once.
        for (int i = 0; i < NCFG; i++) begin
            cnt[i] = 0; adj[i] = 0; prev[i] = 1'b0;
        end
        tx_busy = 1'b1;
        for (int k = 0; k < MEAS_N; k++) begin
            step_cycle();
            for (int i = 0; i < NCFG; i++) begin
                if (tk[i]) cnt[i]++;
                if (tk[i] && prev[i]) adj[i]++;
                prev[i] = tk[i];
            end
        end
        idle(2);

        // Walk the parameter table.
        for (int i = 0; i < NCFG; i++) begin
            longint st;
            longint expc;
            real    rate;
            real    err;
            st   = exp_step(CFG_CLK[i], CFG_BAUD[i]);
            expc = (longint'(MEAS_N) * st) >> W;
            check(cnt[i] == expc, "R2", $sformatf("tick count cfg%0d", i), cnt[i], expc);
            rate = real'(cnt[i]) * real'(CFG_CLK[i]) / real'(MEAS_N);
            err  = (rate - real'(CFG_BAUD[i])) / real'(CFG_BAUD[i]);
            if (err < 0.0) err = -err;
            check(err < 0.005, "R7", $sformatf("measured rate cfg%0d", i),
                  longint'(rate), CFG_BAUD[i]);
            if (st < (longint'(1) << (W - 1)))
                check(adj[i] == 0, "R3", $sformatf("adjacent ticks cfg%0d", i), adj[i], 0);
            else
                check(adj[i] > 0, "R3", $sformatf("adjacent ticks present cfg%0d", i), adj[i], 1);
        end

        // R6 / R1: first tick latency for step 151 and the exact-carry step 16384.
        tx_busy = 1'b1;
        cycles_to_tick(0, 1000, n);
        check(n == first0, "R6", "first tick latency cfg0 (R1 step 151)", n, first0);
        idle(2);
        tx_busy = 1'b1;
        cycles_to_tick(3, 100, n);
        check(n == 4, "R6", "first tick latency cfg3 (R1 step 16384)", n, 4);
        idle(2);

        // R4: idle gap discards a nearly full phase.
        tx_busy = 1'b1;
        repeat (int'(first0) - 1) step_cycle();
        tx_busy = 1'b0;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            step_cycle();
            if (tk[0]) bad++;
        end
        check(bad == 0, "R4", "ticks after busy drop", bad, 0);
        tx_busy = 1'b1;
        cycles_to_tick(0, 1000, n);
        check(n == first0, "R4", "latency after idle gap", n, first0);
        idle(2);

        // R5: reset while busy clears the phase.
        tx_busy = 1'b1;
        repeat (int'(first0) - 1) step_cycle();
        rst_n = 1'b0;
        step_cycle();
        check(tk == '0, "R5", "ticks after reset edge", longint'(tk), 0);
        rst_n = 1'b1;
        cycles_to_tick(0, 1000, n);
        check(n == first0, "R5", "latency after reset", n, first0);
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule